// File: doc/BRIEF.md
# Host Register Bank with Indirect Window and Key-Triggered Reset

This block is the processor-facing register bank of a controller that bridges an 8-bit parallel host bus to a two-wire serial bus. The host sees four slots selected by a 2-bit address. It uses active-low chip enable, read and write strobes. The slot at address 00 does different things by direction: a read returns the engine status code, and a write loads a small pointer. The slot at address 10 is a window onto seven further configuration registers, and that pointer picks which one. The other two slots hold the transfer data byte and the control byte.

The serial engine sits outside this block. It gives the bank a status code and a request to raise the interrupt flag, and it sends a pulse when it sees a STOP on the bus. In return it reads the control bits, the data byte and the window registers from dedicated outputs. The bank drives an active-low interrupt. The flag is cleared by any host write to the control slot, and the host can never set it.

A soft reset is started by writing two key bytes one after the other to one window register. It returns the bank to its power-up state, including the key tracker itself. Host strobes are synchronised into the core clock, and each write takes effect when the combined write strobe is released.

Top module: `pbr_host_regs`

## Requirements
- R1: After reset the status slot reads F8h, the control and data slots read 00h, irq_n is 1, and the window registers hold count 01h, own address E0h, SCL low 9Dh, SCL high 86h, timeout FFh and bus mode 00h.
- R2: At address 00 a read returns {status code, 2'b00} and a write loads the pointer. The write does not change what the status slot reads.
- R3: A write is committed only after the combined strobe (cs_n and wr_n both low) is released. While the strobe is held low, no register changes.
- R4: Address 10 reads and writes the window register selected by pointer bits 2:0, at indices 0 count, 1 own address, 2 SCL low, 3 SCL high, 4 timeout, 5 key, 6 bus mode. Higher pointer bits are ignored.
- R5: Pointer value 7 selects a reserved slot that reads 00h and ignores writes. Index 5 is write-only and always reads 00h.
- R6: The bus-mode register keeps only bits 1:0, and its other bits read 0.
- R7: An engine interrupt request loads the 6-bit status code into bits 7:2 of the status slot and sets the interrupt flag, control bit 3. Bits 1:0 of the status slot read 0.
- R8: Any host write to the control slot clears bit 3 (SI), whatever value is written. Bits 2:1 always read 0. Bit 7 (AA), bit 6 (ENSIO), bit 5 (STA), bit 4 (STO) and bit 0 (MODE) take the written value.
- R9: If an engine interrupt request lands in the same cycle as a control write, SI ends up set.
- R10: A STOP pulse clears STO. If it lands in the same cycle as a control write, the written STO value is kept.
- R11: irq_n is 0 exactly when SI and ENSIO are both 1, delayed by one clock. With ENSIO at 0, irq_n stays 1 even if SI is set.
- R12: Writing A5h and then 5Ah to window index 5, with no other host write between them, restores every R1 default, including the pointer.
- R13: The key is abandoned if any other host write comes between the two bytes, or if the second byte is not 5Ah. In that case no register is reset.
- R14: Address 01 is a read/write data byte, and its value is driven on dat_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip enable, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| addr | input | 2 | Host slot select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data for the addressed slot |
| rdata_oe | output | 1 | Synchronised read-active indication |
| irq_n | output | 1 | Interrupt, active low |
| eng_status | input | 6 | Status code from the serial engine |
| eng_set_si | input | 1 | Engine request to set the interrupt flag and latch status |
| eng_stop_det | input | 1 | One-cycle pulse: STOP seen on the bus |
| ctl_o | output | 8 | Control byte to the engine |
| dat_o | output | 8 | Data byte to the engine |
| bcount_o | output | 8 | Byte count register |
| own_addr_o | output | 8 | Own address register |
| scl_lo_o | output | 8 | SCL low period register |
| scl_hi_o | output | 8 | SCL high period register |
| tmo_o | output | 8 | Timeout register |
| busmode_o | output | 2 | Bus speed mode bits |

## Verification
Two pairs of events can fall in the same cycle as the commit of a host control write: an engine interrupt request, and a STOP pulse. The bench releases the write strobe on a falling clock edge and counts through the synchroniser and the edge detector. It then raises the engine pulse for exactly the clock edge on which the control write commits. The outcome is judged at the ports. For the interrupt case, SI must be set in ctl_o and irq_n must be low afterwards. For the STOP case, STO must keep the value just written.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  localparam int IND_REGS = 7;

  localparam int IDX_COUNT = 0;
  localparam int IDX_OWN   = 1;
  localparam int IDX_SCLLO = 2;
  localparam int IDX_SCLHI = 3;
  localparam int IDX_TMO   = 4;
  localparam int IDX_KEY   = 5;
  localparam int IDX_MODE  = 6;

  localparam int CB_AA   = 7;
  localparam int CB_ENS  = 6;
  localparam int CB_STA  = 5;
  localparam int CB_STO  = 4;
  localparam int CB_SI   = 3;
  localparam int CB_MODE = 0;

  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;
  localparam logic [5:0] STAT_IDLE  = 6'h3E;

  typedef enum logic [1:0] {
    SLOT_STAT_PTR = 2'b00,
    SLOT_DATA     = 2'b01,
    SLOT_WINDOW   = 2'b10,
    SLOT_CTRL     = 2'b11
  } slot_e;

  function automatic logic [7:0] ind_default(input int idx);
    case (idx)
      IDX_COUNT: return 8'h01;
      IDX_OWN:   return 8'hE0;
      IDX_SCLLO: return 8'h9D;
      IDX_SCLHI: return 8'h86;
      IDX_TMO:   return 8'hFF;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] ind_wmask(input int idx);
    case (idx)
      IDX_KEY:  return 8'h00;
      IDX_MODE: return 8'h03;
      default:  return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/pbr_sync.sv
module pbr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pbr_ind_file.sv
module pbr_ind_file
  import pbr_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PW   = 3,
  parameter int NREG = IND_REGS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PW-1:0]    ptr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_data,
  output logic [NREG*DW-1:0] regs_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] DEF = DW'(ind_default(i));
    localparam logic [DW-1:0] MSK = DW'(ind_wmask(i));
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                        q <= DEF;
      else if (we && ptr == PW'(i))   q <= wdata & MSK;
    end
    assign regs_flat[i*DW +: DW] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(ptr) == i) rd_data = regs_flat[i*DW +: DW];
  end

  // R5: a write to a reserved pointer leaves every window register untouched
  a_r5_reserved_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (we && int'(ptr) >= NREG) |=> $stable(regs_flat));
endmodule

// File: rtl/pbr_key_det.sv
module pbr_key_det
  import pbr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_rst,
  input  logic          commit,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  output logic          fire
);
  logic armed;
  logic fire_q;

  always_ff @(posedge clk) begin
    if (core_rst)    armed <= 1'b0;
    else if (commit) armed <= sel && (wdata == DW'(KEY_FIRST));
  end

  always_ff @(posedge clk) begin
    if (rst) fire_q <= 1'b0;
    else     fire_q <= commit && sel && armed && (wdata == DW'(KEY_SECOND));
  end

  assign fire = fire_q;

  // R12: the reset pulse only follows an armed first key byte
  a_r12_fire_needs_arm: assert property (@(posedge clk) disable iff (rst)
    fire_q |-> $past(armed));
  // R13: any write elsewhere abandons a started key
  a_r13_other_write_disarms: assert property (@(posedge clk) disable iff (core_rst)
    (commit && !sel) |=> !armed);
endmodule

// File: rtl/pbr_host_regs.sv
module pbr_host_regs
  import pbr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int PW          = 3,
  parameter int SW          = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          irq_n,
  input  logic [SW-1:0] eng_status,
  input  logic          eng_set_si,
  input  logic          eng_stop_det,
  output logic [DW-1:0] ctl_o,
  output logic [DW-1:0] dat_o,
  output logic [DW-1:0] bcount_o,
  output logic [DW-1:0] own_addr_o,
  output logic [DW-1:0] scl_lo_o,
  output logic [DW-1:0] scl_hi_o,
  output logic [DW-1:0] tmo_o,
  output logic [1:0]    busmode_o
);
  localparam int NREG = IND_REGS;
  localparam int PADW = DW - SW;

  logic [1:0]       strb_s;
  logic             wr_prev;
  logic             commit;
  logic             key_fire;
  logic             core_rst;
  logic [PW-1:0]    ptr_q;
  logic [SW-1:0]    stat_q;
  logic [DW-1:0]    dat_q;
  logic [DW-1:0]    ctl_q;
  logic [DW-1:0]    ind_rd;
  logic [NREG*DW-1:0] ind_flat;
  logic             ptr_we, dat_we, win_we, ctl_we;
  logic [DW-1:0]    rd_mux;

  assign core_rst = rst | key_fire;

  pbr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({~cs_n & ~wr_n, ~cs_n & ~rd_n}),
    .q   (strb_s)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_prev <= 1'b0;
    else     wr_prev <= strb_s[1];
  end

  assign commit = wr_prev & ~strb_s[1];
  assign ptr_we = commit && (addr == AW'(SLOT_STAT_PTR));
  assign dat_we = commit && (addr == AW'(SLOT_DATA));
  assign win_we = commit && (addr == AW'(SLOT_WINDOW));
  assign ctl_we = commit && (addr == AW'(SLOT_CTRL));

  pbr_key_det #(.DW(DW)) u_key (
    .clk      (clk),
    .rst      (rst),
    .core_rst (core_rst),
    .commit   (commit),
    .sel      (win_we && ptr_q == PW'(IDX_KEY)),
    .wdata    (wdata),
    .fire     (key_fire)
  );

  pbr_ind_file #(.DW(DW), .PW(PW), .NREG(NREG)) u_ind (
    .clk       (clk),
    .rst       (core_rst),
    .we        (win_we),
    .ptr       (ptr_q),
    .wdata     (wdata),
    .rd_data   (ind_rd),
    .regs_flat (ind_flat)
  );

  always_ff @(posedge clk) begin
    if (core_rst)    ptr_q <= '0;
    else if (ptr_we) ptr_q <= wdata[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (core_rst)        stat_q <= STAT_IDLE;
    else if (eng_set_si) stat_q <= eng_status;
  end

  always_ff @(posedge clk) begin
    if (core_rst)    dat_q <= '0;
    else if (dat_we) dat_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      ctl_q <= '0;
    end else begin
      if (ctl_we) begin
        ctl_q[CB_AA]   <= wdata[CB_AA];
        ctl_q[CB_ENS]  <= wdata[CB_ENS];
        ctl_q[CB_STA]  <= wdata[CB_STA];
        ctl_q[CB_STO]  <= wdata[CB_STO];
        ctl_q[CB_MODE] <= wdata[CB_MODE];
      end else if (eng_stop_det) begin
        ctl_q[CB_STO]  <= 1'b0;
      end
      if (eng_set_si)  ctl_q[CB_SI] <= 1'b1;
      else if (ctl_we) ctl_q[CB_SI] <= 1'b0;
    end
  end

  always_comb begin
    case (slot_e'(addr))
      SLOT_STAT_PTR: rd_mux = {stat_q, {PADW{1'b0}}};
      SLOT_DATA:     rd_mux = dat_q;
      SLOT_WINDOW:   rd_mux = ind_rd;
      default:       rd_mux = ctl_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
      irq_n    <= 1'b1;
    end else begin
      rdata    <= rd_mux;
      rdata_oe <= strb_s[0];
      irq_n    <= ~(ctl_q[CB_SI] & ctl_q[CB_ENS]);
    end
  end

  assign ctl_o      = ctl_q;
  assign dat_o      = dat_q;
  assign bcount_o   = ind_flat[IDX_COUNT*DW +: DW];
  assign own_addr_o = ind_flat[IDX_OWN*DW +: DW];
  assign scl_lo_o   = ind_flat[IDX_SCLLO*DW +: DW];
  assign scl_hi_o   = ind_flat[IDX_SCLHI*DW +: DW];
  assign tmo_o      = ind_flat[IDX_TMO*DW +: DW];
  assign busmode_o  = ind_flat[IDX_MODE*DW +: 2];

  // R7: SI only rises after an engine request
  a_r7_si_from_engine: assert property (@(posedge clk) disable iff (core_rst)
    $rose(ctl_q[CB_SI]) |-> $past(eng_set_si));
  // R8: a control write with no competing request leaves SI clear
  a_r8_ctl_write_clears_si: assert property (@(posedge clk) disable iff (core_rst)
    (ctl_we && !eng_set_si) |=> !ctl_o[CB_SI]);
  // R10: a STOP pulse alone clears STO
  a_r10_stop_clears_sto: assert property (@(posedge clk) disable iff (core_rst)
    (eng_stop_det && !ctl_we) |=> !ctl_o[CB_STO]);
  // R11: with SI low the interrupt line is released one cycle later
  a_r11_irq_released: assert property (@(posedge clk) disable iff (core_rst)
    !ctl_q[CB_SI] |=> irq_n);
endmodule

// File: tb/sim_pbr_host_regs.sv
`timescale 1ns/1ps
module sim_pbr_host_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic rdata_oe, irq_n;
  logic [5:0] eng_status = 6'h00;
  logic eng_set_si = 1'b0, eng_stop_det = 1'b0;
  logic [7:0] ctl_o, dat_o, bcount_o, own_addr_o, scl_lo_o, scl_hi_o, tmo_o;
  logic [1:0] busmode_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pbr_host_regs u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .irq_n(irq_n), .eng_status(eng_status), .eng_set_si(eng_set_si),
    .eng_stop_det(eng_stop_det), .ctl_o(ctl_o), .dat_o(dat_o),
    .bcount_o(bcount_o), .own_addr_o(own_addr_o), .scl_lo_o(scl_lo_o),
    .scl_hi_o(scl_hi_o), .tmo_o(tmo_o), .busmode_o(busmode_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // side: 0 none, 1 engine interrupt request, 2 STOP pulse, on the commit edge
  task automatic hw(input logic [1:0] a, input logic [7:0] d, input int side);
    @(negedge clk); addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    if (side == 1) eng_set_si = 1'b1;
    if (side == 2) eng_stop_det = 1'b1;
    @(negedge clk); eng_set_si = 1'b0; eng_stop_det = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic hr(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; cs_n = 1'b0; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    d = rdata;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic iw(input logic [7:0] p, input logic [7:0] d);
    hw(2'b00, p, 0); hw(2'b10, d, 0);
  endtask

  task automatic ir(input logic [7:0] p, output logic [7:0] d);
    hw(2'b00, p, 0); hr(2'b10, d);
  endtask

  task automatic eng_irq(input logic [5:0] code);
    @(negedge clk); eng_status = code; eng_set_si = 1'b1;
    @(negedge clk); eng_set_si = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_defaults;
    logic [7:0] v;
    hr(2'b00, v); chk("R1 status", v, 8'hF8);
    hr(2'b11, v); chk("R1 control", v, 8'h00);
    hr(2'b01, v); chk("R1 data", v, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 count", bcount_o, 8'h01);
    chk("R1 own", own_addr_o, 8'hE0);
    chk("R1 scl lo", scl_lo_o, 8'h9D);
    chk("R1 scl hi", scl_hi_o, 8'h86);
    chk("R1 timeout", tmo_o, 8'hFF);
    chk("R1 mode", {6'd0, busmode_o}, 8'h00);
  endtask

  task automatic t_window;
    logic [7:0] v;
    ir(8'h01, v); chk("R4 read own", v, 8'hE0);
    ir(8'h04, v); chk("R4 read timeout", v, 8'hFF);
    iw(8'h02, 8'h33); chk("R4 scl lo port", scl_lo_o, 8'h33);
    hr(2'b10, v); chk("R4 scl lo readback", v, 8'h33);
    hr(2'b00, v); chk("R2 status after ptr write", v, 8'hF8);
    iw(8'h0B, 8'h44); chk("R4 high ptr bits ignored", scl_hi_o, 8'h44);
    chk("R4 scl lo untouched", scl_lo_o, 8'h33);
  endtask

  task automatic t_reserved;
    logic [7:0] v;
    iw(8'h07, 8'h77);
    hr(2'b10, v); chk("R5 reserved reads zero", v, 8'h00);
    chk("R5 reserved no effect lo", scl_lo_o, 8'h33);
    chk("R5 reserved no effect cnt", bcount_o, 8'h01);
    ir(8'h05, v); chk("R5 key slot reads zero", v, 8'h00);
    iw(8'h06, 8'hFF);
    hr(2'b10, v); chk("R6 mode masked", v, 8'h03);
    chk("R6 mode port", {6'd0, busmode_o}, 8'h03);
  endtask

  task automatic t_strobe;
    logic [7:0] v;
    @(negedge clk); addr = 2'b01; wdata = 8'h5C; cs_n = 1'b0; wr_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R3 no change while held", dat_o, 8'h00);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 committed on release", dat_o, 8'h5C);
    hr(2'b01, v); chk("R14 data readback", v, 8'h5C);
  endtask

  task automatic t_ctrl;
    logic [7:0] v;
    eng_irq(6'h12);
    hr(2'b00, v); chk("R7 status latched", v, 8'h48);
    chk("R7 SI set", {7'd0, ctl_o[3]}, 8'h01);
    chk("R11 ENSIO off no irq", {7'd0, irq_n}, 8'h01);
    hw(2'b11, 8'hCF, 0);
    hr(2'b11, v); chk("R8 write clears SI, bits 2:1 zero", v, 8'hC1);
    eng_irq(6'h2A);
    chk("R11 irq asserted", {7'd0, irq_n}, 8'h00);
    hw(2'b11, 8'h40, 0);
    chk("R11 irq released", {7'd0, irq_n}, 8'h01);
    chk("R8 SI cleared", {7'd0, ctl_o[3]}, 8'h00);
    hw(2'b11, 8'h40, 1);
    chk("R9 same-cycle set wins", {7'd0, ctl_o[3]}, 8'h01);
    chk("R9 irq low after collision", {7'd0, irq_n}, 8'h00);
    hw(2'b11, 8'h50, 0);
    chk("R10 STO written", {7'd0, ctl_o[4]}, 8'h01);
    @(negedge clk); eng_stop_det = 1'b1;
    @(negedge clk); eng_stop_det = 1'b0;
    @(negedge clk);
    chk("R10 STOP clears STO", {7'd0, ctl_o[4]}, 8'h00);
    hw(2'b11, 8'h50, 2);
    chk("R10 host write beats STOP", {7'd0, ctl_o[4]}, 8'h01);
  endtask

  task automatic t_key;
    logic [7:0] v;
    hw(2'b01, 8'h11, 0);
    iw(8'h05, 8'hA5);
    hw(2'b01, 8'h22, 0);
    hw(2'b10, 8'h5A, 0);
    repeat (4) @(negedge clk);
    chk("R13 interrupted key no reset", dat_o, 8'h22);
    hw(2'b10, 8'hA5, 0);
    hw(2'b10, 8'h5B, 0);
    hw(2'b10, 8'h5A, 0);
    repeat (4) @(negedge clk);
    chk("R13 wrong second byte no reset", scl_lo_o, 8'h33);
    hw(2'b10, 8'hA5, 0);
    hw(2'b10, 8'h5A, 0);
    repeat (4) @(negedge clk);
    chk("R12 scl lo default", scl_lo_o, 8'h9D);
    chk("R12 data default", dat_o, 8'h00);
    chk("R12 control default", ctl_o, 8'h00);
    chk("R12 irq released", {7'd0, irq_n}, 8'h01);
    hr(2'b00, v); chk("R12 status default", v, 8'hF8);
    hr(2'b10, v); chk("R12 pointer default", v, 8'h01);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_defaults;
    t_window;
    t_reserved;
    t_strobe;
    t_ctrl;
    t_key;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule